// File: doc/BRIEF.md
# Tone Frequency Measurement Counter

This block measures the frequency of a squared-up audio tone. A measurement window opens on the first tone transition seen while the block is idle. The window is 511 measuring ticks long. During the window the block counts every transition, rising and falling, so the count is twice the number of whole cycles. It also notes the tick count at the most recent transition. When the window closes it reports the half-cycle count N and the residual R. R is the number of ticks between the last transition and the end of the window. From these the host computes frequency as K·N/(511−R), where K is half the tick rate.

The measuring tick comes from a reference-rate enable (one pulse per reference clock period) divided by a band-dependent factor. The slow divider gives the mid band its double-length window. The fast divider serves the high and extended bands. A measurement succeeds when enough transitions were seen and no transition gap was too long. On success, a one-cycle completion strobe fires and the result word is loaded. Otherwise a one-cycle abort strobe fires and the previous result is kept.

Top module: `tfm_meter`

## Requirements
- R1: A synchronous reset, including one asserted during a window, clears the result word to 0, keeps both strobes low and returns the block to idle.
- R2: While idle, the first tone transition opens a window. That transition is not counted. The band code is captured at that transition, so band changes during a window do not affect it.
- R3: The window closes on the 511th measuring tick. A tick is every DIV_SLOW-th reference enable for band code 01, and every DIV_FAST-th for codes 00, 10 and 11, with code 11 handled as 00. With the reference enable held high, a strobe is visible 511·D+2 clock edges after the opening input change, where D is the active divider.
- R4: The upper byte of the result word holds N, the number of tone transitions after the opening one. Both polarities count. A transition on the closing tick is included, and N saturates at 255.
- R5: The lower byte of the result word holds R = 511 minus the tick count at the last counted transition.
- R6: The completion strobe is a one-cycle pulse, and the result word changes only in the cycle in which it is high.
- R7: If fewer than 2 transitions were counted when the window closes, the abort strobe fires instead of the completion strobe, and the result word keeps its value.
- R8: If more than GAP_LIMIT (default 255) ticks pass after the last transition, or after the window opened, with no new transition, the window is abandoned with an abort strobe. The strobe is visible (GAP_LIMIT+1)·D+2 edges after the opening input change when no transition follows it. A transition on the same tick that would exceed the limit restarts the gap instead.
- R9: Completion and abort are never high together. After either one, the block stays idle until the next tone transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_in | input | 1 | Digitised tone, already noise filtered |
| ref_en | input | 1 | Reference-rate enable, divided down to the measuring tick |
| band_sel | input | 2 | Band code: 00 high, 01 mid, 10 extended, 11 as high |
| result | output | 16 | {N, R} of the last successful measurement |
| done | output | 1 | One-cycle completion strobe |
| abort | output | 1 | One-cycle abort strobe |

## Verification
Two events can land on the same clock cycle, and these are the cases most exposed to priority errors.

The first is a tone transition on the very tick that closes the window. The bench drives a period that divides the window exactly. It then expects that transition to be counted and R to read 0.

The second is a transition on the tick at which the gap would exceed its limit. The bench drives a period of exactly GAP_LIMIT+1 ticks. It expects that transition to restart the gap rather than trigger the abort, so the window instead closes with N=1 and aborts on the count rule. A matching run with a period of exactly GAP_LIMIT ticks confirms that the window completes with R=1.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    typedef enum logic [1:0] {
        BAND_HIGH = 2'b00,
        BAND_MID  = 2'b01,
        BAND_EXT  = 2'b10,
        BAND_RSV  = 2'b11
    } band_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } meas_st_e;

endpackage

// File: rtl/tfm_edge_det.sv
module tfm_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic tone_in,
    output logic edge_o
);

    typedef struct packed {
        logic smp;
        logic prv;
        logic loaded;
        logic vld;
    } edge_reg_t;

    edge_reg_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.smp    = tone_in;
        st_d.prv    = st_q.smp;
        st_d.loaded = 1'b1;
        st_d.vld    = st_q.loaded;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // both polarities count; nothing reported until prv holds a real sample
    assign edge_o = st_q.vld & (st_q.smp ^ st_q.prv);

endmodule

// File: rtl/tfm_tick_gen.sv
module tfm_tick_gen #(
    parameter int DIV_SLOW = 144,
    parameter int DIV_FAST = 72
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic ref_en,
    input  logic slow_sel,
    output logic tick
);

    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] lim;

    generate
        if (DIV_SLOW == DIV_FAST) begin : g_one_rate
            assign lim = PRE_W'(DIV_FAST - 1);
        end else begin : g_two_rate
            assign lim = slow_sel ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
        end
    endgenerate

    assign tick = ref_en && (pre_q == lim);

    always_comb begin
        pre_d = pre_q;
        if (restart)
            pre_d = '0;
        else if (ref_en)
            pre_d = (pre_q == lim) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

endmodule

// File: rtl/tfm_meter.sv
module tfm_meter #(
    parameter int DIV_SLOW  = 144,
    parameter int DIV_FAST  = 72,
    parameter int WIN_TICKS = 511,
    parameter int GAP_LIMIT = 255,
    parameter int N_W       = 8,
    parameter int R_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tone_in,
    input  logic                 ref_en,
    input  logic [1:0]           band_sel,
    output logic [N_W+R_W-1:0]   result,
    output logic                 done,
    output logic                 abort
);
    import tfm_pkg::*;

    localparam int TICK_W = $clog2(WIN_TICKS + 1);
    localparam int GAP_W  = $clog2(GAP_LIMIT + 2);
    localparam int RES_W  = N_W + R_W;

    typedef struct packed {
        meas_st_e           st;
        logic               slow;
        logic [TICK_W-1:0]  tcnt;
        logic [GAP_W-1:0]   gap;
        logic [N_W-1:0]     n;
        logic [TICK_W-1:0]  last;
        logic [RES_W-1:0]   res;
        logic               done;
        logic               abort;
    } meas_reg_t;

    meas_reg_t q, d;
    logic      edge_w, tick_w, restart_w;
    logic [TICK_W-1:0] rem;

    tfm_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .tone_in (tone_in),
        .edge_o  (edge_w)
    );

    assign restart_w = (q.st == ST_IDLE) && edge_w;

    tfm_tick_gen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart_w),
        .ref_en   (ref_en),
        .slow_sel (q.slow),
        .tick     (tick_w)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.abort = 1'b0;
        rem     = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (edge_w) begin
                    d.st   = ST_RUN;
                    d.slow = (band_e'(band_sel) == BAND_MID);
                    d.tcnt = '0;
                    d.gap  = '0;
                    d.n    = '0;
                    d.last = '0;
                end
            end
            ST_RUN: begin
                d.tcnt = q.tcnt + TICK_W'(tick_w);
                d.gap  = q.gap + GAP_W'(tick_w);
                if (edge_w) begin
                    if (q.n != {N_W{1'b1}})
                        d.n = q.n + 1'b1;
                    d.last = d.tcnt;
                    d.gap  = '0;
                end
                rem = TICK_W'(WIN_TICKS) - d.last;
                if (d.tcnt == TICK_W'(WIN_TICKS)) begin
                    d.st = ST_IDLE;
                    if (d.n < N_W'(2)) begin
                        d.abort = 1'b1;
                    end else begin
                        d.done = 1'b1;
                        d.res  = {d.n, rem[R_W-1:0]};
                    end
                end else if (d.gap > GAP_W'(GAP_LIMIT)) begin
                    d.st    = ST_IDLE;
                    d.abort = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign result = q.res;
    assign done   = q.done;
    assign abort  = q.abort;

endmodule

// File: rtl/tfm_meter_chk.sv
module tfm_meter_chk #(
    parameter int N_W = 8,
    parameter int R_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               abort,
    input logic [N_W+R_W-1:0] result
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == '0) && !done && !abort);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && abort));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7
    min_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (result[N_W+R_W-1:R_W] >= N_W'(2)));

endmodule

bind tfm_meter tfm_meter_chk #(.N_W(N_W), .R_W(R_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .abort  (abort),
    .result (result)
);

// File: tb/sim_tfm_meter.sv
`timescale 1ns/1ps
module sim_tfm_meter;

    localparam int W  = 511;
    localparam int G  = 255;
    localparam int DS = 4;
    localparam int DF = 2;
    localparam int NV = 10;

    localparam int V_BAND [NV] = '{0, 1, 2, 3, 1, 0, 0, 0, 0, 1};
    localparam int V_PER  [NV] = '{10, 10, 7, 13, 45, 1, 510, 512, 10, 10};
    localparam int V_TOG  [NV] = '{103, 205, 147, 79, 46, 1023, 3, 2, 1, 1};
    localparam int V_OK   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tone = 1'b0;
    logic        ref_en = 1'b1;
    logic [1:0]  band = 2'b00;
    logic [15:0] result;
    logic        done, abort;

    int total = 0;
    int bad = 0;
    int prev_res = 0;

    always #4 clk = ~clk;

    tfm_meter #(.DIV_SLOW(DS), .DIV_FAST(DF)) u0 (
        .clk      (clk),
        .rst      (rst),
        .tone_in  (tone),
        .ref_en   (ref_en),
        .band_sel (band),
        .result   (result),
        .done     (done),
        .abort    (abort)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int div_of(input int b);
        return (b == 1) ? DS : DF;
    endfunction

    // outcome: 0 none, 1 done, 2 abort; lat: negedges from opening change
    task automatic run(input int b, input int p, input int ntog,
                       input int chg_at, input int chg_band,
                       output int outcome, output int lat);
        int cyc;
        int tog;
        band = 2'(b);
        @(negedge clk);
        tone = ~tone;
        tog = 1;
        cyc = 0;
        outcome = 0;
        while (outcome == 0 && cyc < 8000) begin
            @(negedge clk);
            cyc++;
            if (done) outcome = 1;
            else if (abort) outcome = 2;
            if (cyc == chg_at) band = 2'(chg_band);
            if (outcome == 0 && tog < ntog && (cyc % p) == 0) begin
                tone = ~tone;
                tog++;
            end
        end
        lat = cyc;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int outc, lat, d, nraw, nexp, rexp, eres, elat;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(result == 16'h0000, "R1", "result after reset", int'(result), 0);
        chk(!done && !abort, "R1", "strobes after reset", int'({done, abort}), 0);

        for (int i = 0; i < NV; i++) begin
            d = div_of(V_BAND[i]);
            run(V_BAND[i], V_PER[i], V_TOG[i], -1, 0, outc, lat);
            if (V_OK[i] != 0) begin
                nraw = (W * d) / V_PER[i];
                nexp = (nraw > 255) ? 255 : nraw;
                rexp = W - (nraw * V_PER[i]) / d;
                eres = nexp * 256 + rexp;
                elat = W * d + 2;
                // R9 outcome, R3 window length, R4/R5 fields
                chk(outc == 1, "R9", "outcome (1=done)", outc, 1);
                chk(lat == elat, "R3", "completion latency", lat, elat);
                chk(int'(result[15:8]) == nexp, "R4", "N field", int'(result[15:8]), nexp);
                chk(int'(result[7:0]) == rexp, "R5", "R field", int'(result[7:0]), rexp);
                prev_res = int'(result);
            end else begin
                elat = (V_TOG[i] == 1) ? (G + 1) * d + 2 : W * d + 2;
                if (V_TOG[i] == 1)
                    chk(lat == elat, "R8", "gap abort latency", lat, elat);
                else
                    chk(lat == elat, "R7", "low count abort latency", lat, elat);
                chk(outc == 2, "R8", "outcome (2=abort)", outc, 2);
                // R6 result held across an abort
                chk(int'(result) == prev_res, "R6", "result kept after abort", int'(result), prev_res);
            end
        end

        // R2 band change mid-window ignored: band 00 captured, switched to 01 later
        run(0, 10, 103, 20, 1, outc, lat);
        chk(outc == 1, "R2", "outcome with band change", outc, 1);
        chk(lat == W * DF + 2, "R2", "latency with band change", lat, W * DF + 2);
        chk(int'(result) == 102 * 256 + 1, "R2", "result with band change", int'(result), 102 * 256 + 1);

        // R1 reset mid-window, then R9 idle with no transitions
        band = 2'b00;
        @(negedge clk);
        for (int k = 0; k < 100; k++) begin
            if (k % 10 == 0) tone = ~tone;
            @(negedge clk);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result == 16'h0000, "R1", "result after mid-window reset", int'(result), 0);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 2100; k++) begin
                @(negedge clk);
                if (done || abort) seen++;
            end
            chk(seen == 0, "R9", "strobes while idle after reset", seen, 0);
        end

        // R6 normal operation resumes and result reloads
        run(3, 13, 79, -1, 0, outc, lat);
        chk(outc == 1 && int'(result) == 78 * 256 + 4, "R6", "result after resume",
            int'(result), 78 * 256 + 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule